// File: doc/BRIEF.md
# Split-Screen Display Address Sequencer

This block produces the fetch addresses for one refresh frame of a 64-row monochrome bitmap panel whose picture is split into two stacked regions. The upper, main region is read from a main base pointer and may come from an image wider than the screen. The lower, menu region is read from a separate menu base pointer and is stored packed. A line fetcher downstream takes one row descriptor at a time (row number, start address, region flag) over a valid/ready handshake and pulls that row's bytes from memory.

A frame begins when the refresh timer pulses `frame_start` while the sequencer is idle. At that moment the sequencer takes a copy of the configuration: both base pointers, the per-line skip count for the main region, the 3-bit pixel offset and the 6-bit menu index. Addresses count nibbles, and every row start is forced to a byte boundary. In the main region, each row start is one row width plus the skip count after the previous one. Offsets of 4 or more cost one further byte per main row. The menu index N places the first menu row at N+1, and the menu then runs to the bottom of the screen. After the last row is accepted, a one-cycle done pulse closes the frame.

Top module: `split_disp_seq`

## Requirements
- R1: During and right after reset `row_valid` and `frame_done` are 0. A reset in the middle of a frame abandons that frame.
- R2: A `frame_start` seen while idle makes row 0 valid on the next cycle, with `row_addr` equal to `main_base` with bit 0 cleared. Rows then appear in order 0 to 63, advancing by one on each cycle in which `row_valid` and `row_ready` are both 1, and `row_addr` bit 0 is always 0.
- R3: While `row_valid` is 1 and `row_ready` is 0, `row_valid`, `row_num`, `row_addr` and `row_is_menu` hold their values.
- R4: Each main-region row after row 0 starts 2*(ROW_BYTES + `overscan`) nibbles after the previous row, modulo 2^ADDR_W.
- R5: When `pix_off` is 4 to 7, each main-region step grows by 2 more nibbles (one byte). Offsets 0 to 3 add nothing.
- R6: Row r is a menu row (`row_is_menu`=1) exactly when r > `menu_idx`. The first menu row starts at `menu_base` with bit 0 cleared. Row 0 is never a menu row.
- R7: Each menu row after the first starts 2*ROW_BYTES nibbles after the previous one, whatever `overscan` and `pix_off` hold.
- R8: With `menu_idx` = 63 all 64 rows are main-region rows.
- R9: The configuration is sampled only when a frame starts. Changes to the inputs and further `frame_start` pulses during a frame do not alter that frame's rows.
- R10: `frame_done` pulses high for exactly one cycle, on the cycle after row 63 is accepted, and at that point `row_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Refresh strobe that starts a frame when idle |
| main_base | input | ADDR_W (20) | Main-region base nibble address |
| menu_base | input | ADDR_W (20) | Menu-region base nibble address |
| overscan | input | OVS_W (12) | Bytes skipped after each main-region row |
| pix_off | input | 3 | Pixel offset; values of 4 or more add a one-byte skip |
| menu_idx | input | ROW_W (6) | Menu index; the menu starts at row menu_idx+1 |
| row_ready | input | 1 | Line fetcher accepts the current row |
| row_valid | output | 1 | Row descriptor is valid |
| row_num | output | ROW_W (6) | Screen row number, 0 at the top |
| row_addr | output | ADDR_W (20) | Row start nibble address |
| row_is_menu | output | 1 | Row belongs to the menu region |
| frame_done | output | 1 | One-cycle pulse after the last row |

## Verification
The hardest case to reach is a frame in which the fetcher stalls while the configuration changes and a second frame strobe arrives. The new values must not leak into the rows still pending, and the address chain must still switch from the main pointer to the menu pointer at the right row. The bench creates this with a directed frame: it drops `row_ready` on chosen rows, and during each stall it scrambles every configuration input and pulses `frame_start`. It then checks every remaining row against a model built from the values captured at the start. The region boundary is also driven to its extremes: index 0 (menu from row 1), 62 (one menu row) and 63 (no menu).

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic {REG_MAIN = 1'b0, REG_MENU = 1'b1} region_e;

  function automatic logic [19:0] unused_pkg_marker();
    return 20'd0;
  endfunction
endpackage

// File: rtl/sds_cfg_latch.sv
module sds_cfg_latch #(
  parameter int ADDR_W    = 20,
  parameter int OVS_W     = 12,
  parameter int ROW_W     = 6,
  parameter int ROW_BYTES = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] menu_base,
  input  logic [OVS_W-1:0]  overscan,
  input  logic [2:0]        pix_off,
  input  logic [ROW_W-1:0]  menu_idx,
  output logic [ADDR_W-1:0] menu_base_q,
  output logic [ADDR_W-1:0] main_stride_q,
  output logic [ROW_W-1:0]  menu_idx_q
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(1));

  logic              extra_byte;
  logic [ADDR_W-1:0] stride_bytes;

  always_comb begin
    extra_byte   = (pix_off >= 3'd4);
    stride_bytes = ADDR_W'(ROW_BYTES) + ADDR_W'(overscan) + ADDR_W'(extra_byte);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      menu_base_q   <= '0;
      main_stride_q <= '0;
      menu_idx_q    <= '1;
    end else if (load) begin
      menu_base_q   <= menu_base & ALIGN_MASK;
      main_stride_q <= stride_bytes << 1;
      menu_idx_q    <= menu_idx;
    end
  end
endmodule

// File: rtl/sds_row_ctr.sv
module sds_row_ctr #(
  parameter int ROWS  = 64,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             adv,
  input  logic [ROW_W-1:0] menu_idx_q,
  output logic [ROW_W-1:0] row_q,
  output logic             valid_q,
  output logic             done_q,
  output sds_pkg::region_e region_q,
  output sds_pkg::region_e next_region,
  output logic             last_row
);
  import sds_pkg::*;
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] next_row;

  always_comb begin
    next_row    = row_q + ROW_W'(1);
    next_region = (next_row > menu_idx_q) ? REG_MENU : REG_MAIN;
    last_row    = (row_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q    <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
      region_q <= REG_MAIN;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        row_q    <= '0;
        valid_q  <= 1'b1;
        region_q <= REG_MAIN;
      end else if (adv) begin
        if (last_row) begin
          valid_q <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          row_q    <= next_row;
          region_q <= next_region;
        end
      end
    end
  end
endmodule

// File: rtl/sds_addr_gen.sv
module sds_addr_gen #(
  parameter int ADDR_W    = 20,
  parameter int ROW_BYTES = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              adv,
  input  logic              last_row,
  input  logic [ADDR_W-1:0] main_base,
  input  logic [ADDR_W-1:0] menu_base_q,
  input  logic [ADDR_W-1:0] main_stride_q,
  input  sds_pkg::region_e  region_q,
  input  sds_pkg::region_e  next_region,
  output logic [ADDR_W-1:0] addr_q
);
  import sds_pkg::*;
  localparam logic [ADDR_W-1:0] MENU_STRIDE = ADDR_W'(2 * ROW_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK  = ~(ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (go) begin
      addr_q <= main_base & ALIGN_MASK;
    end else if (adv && !last_row) begin
      if (next_region == REG_MENU && region_q == REG_MAIN)
        addr_q <= menu_base_q;
      else if (next_region == REG_MENU)
        addr_q <= addr_q + MENU_STRIDE;
      else
        addr_q <= addr_q + main_stride_q;
    end
  end
endmodule

// File: rtl/split_disp_seq.sv
module split_disp_seq #(
  parameter int ROWS      = 64,
  parameter int ADDR_W    = 20,
  parameter int OVS_W     = 12,
  parameter int ROW_BYTES = 17,
  localparam int ROW_W    = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] main_base,
  input  logic [ADDR_W-1:0] menu_base,
  input  logic [OVS_W-1:0]  overscan,
  input  logic [2:0]        pix_off,
  input  logic [ROW_W-1:0]  menu_idx,
  input  logic              row_ready,
  output logic              row_valid,
  output logic [ROW_W-1:0]  row_num,
  output logic [ADDR_W-1:0] row_addr,
  output logic              row_is_menu,
  output logic              frame_done
);
  import sds_pkg::*;

  logic              go, adv, last_row;
  logic [ADDR_W-1:0] menu_base_q, main_stride_q;
  logic [ROW_W-1:0]  menu_idx_q;
  region_e           region_q, next_region;

  assign go  = frame_start && !row_valid;
  assign adv = row_valid && row_ready;

  sds_cfg_latch #(
    .ADDR_W(ADDR_W), .OVS_W(OVS_W), .ROW_W(ROW_W), .ROW_BYTES(ROW_BYTES)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(go),
    .menu_base(menu_base), .overscan(overscan), .pix_off(pix_off),
    .menu_idx(menu_idx),
    .menu_base_q(menu_base_q), .main_stride_q(main_stride_q),
    .menu_idx_q(menu_idx_q)
  );

  sds_row_ctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_ctr (
    .clk(clk), .rst(rst), .go(go), .adv(adv), .menu_idx_q(menu_idx_q),
    .row_q(row_num), .valid_q(row_valid), .done_q(frame_done),
    .region_q(region_q), .next_region(next_region), .last_row(last_row)
  );

  sds_addr_gen #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_addr (
    .clk(clk), .rst(rst), .go(go), .adv(adv), .last_row(last_row),
    .main_base(main_base), .menu_base_q(menu_base_q),
    .main_stride_q(main_stride_q), .region_q(region_q),
    .next_region(next_region), .addr_q(row_addr)
  );

  assign row_is_menu = (region_q == REG_MENU);
endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
  parameter int ROW_W  = 6,
  parameter int ADDR_W = 20,
  parameter int ROWS   = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              row_valid,
  input logic              row_ready,
  input logic [ROW_W-1:0]  row_num,
  input logic [ADDR_W-1:0] row_addr,
  input logic              row_is_menu,
  input logic              frame_done
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    row_valid && !row_ready |=> row_valid && $stable(row_num) &&
      $stable(row_addr) && $stable(row_is_menu));

  assert_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    row_valid |-> row_addr[0] == 1'b0);

  assert_row_step_R2: assert property (@(posedge clk) disable iff (rst)
    row_valid && row_ready && row_num != LAST |=>
      row_valid && row_num == ROW_W'($past(row_num) + 1'b1));

  assert_top_main_R6: assert property (@(posedge clk) disable iff (rst)
    row_valid && row_num == '0 |-> !row_is_menu);

  assert_menu_to_end_R6: assert property (@(posedge clk) disable iff (rst)
    row_valid && row_ready && row_is_menu && row_num != LAST |=> row_is_menu);

  assert_done_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_done) |-> $past(row_valid && row_ready && row_num == LAST));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !row_valid);
endmodule

bind split_disp_seq sds_checker #(.ROW_W(ROW_W), .ADDR_W(ADDR_W), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst(rst), .row_valid(row_valid), .row_ready(row_ready),
  .row_num(row_num), .row_addr(row_addr), .row_is_menu(row_is_menu),
  .frame_done(frame_done)
);

// File: tb/split_disp_seq_test.sv
module split_disp_seq_test;
  localparam int RB = 17;
  localparam int NV = 5;

  localparam logic [19:0] V_MAIN [NV] = '{20'h12340, 20'h12341, 20'hF097C, 20'h00100, 20'hFFFF0};
  localparam logic [19:0] V_MENU [NV] = '{20'h56780, 20'h02000, 20'hA0001, 20'h00200, 20'hFFFE0};
  localparam logic [11:0] V_OVS  [NV] = '{12'd0, 12'd3, 12'd0, 12'd7, 12'd1};
  localparam logic [2:0]  V_PIX  [NV] = '{3'd0, 3'd5, 3'd4, 3'd3, 3'd7};
  localparam logic [5:0]  V_IDX  [NV] = '{6'd55, 6'd62, 6'd63, 6'd0, 6'd30};

  logic clk = 0, rst = 1, frame_start = 0, row_ready = 1;
  logic [19:0] main_base = 0, menu_base = 0;
  logic [11:0] overscan = 0;
  logic [2:0]  pix_off = 0;
  logic [5:0]  menu_idx = 0;
  logic row_valid, row_is_menu, frame_done;
  logic [5:0]  row_num;
  logic [19:0] row_addr;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  split_disp_seq uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .main_base(main_base),
    .menu_base(menu_base), .overscan(overscan), .pix_off(pix_off),
    .menu_idx(menu_idx), .row_ready(row_ready), .row_valid(row_valid),
    .row_num(row_num), .row_addr(row_addr), .row_is_menu(row_is_menu),
    .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_row(input int r, input logic [19:0] ea, input bit em,
                           input string areq, input string mreq);
    chk(row_valid === 1'b1, "R2 valid", 32'(row_valid), 1);
    chk(row_num === 6'(r), "R2 row", 32'(row_num), 32'(r));
    chk(row_addr === ea, areq, 32'(row_addr), 32'(ea));
    chk(row_is_menu === em, mreq, 32'(row_is_menu), 32'(em));
  endtask

  task automatic run_frame(input logic [19:0] mb, input logic [19:0] nb,
                           input logic [11:0] ov, input logic [2:0] px,
                           input logic [5:0] ix, input bit stall);
    logic [19:0] ea;
    bit em, pm;
    string areq, mreq;
    main_base = mb; menu_base = nb; overscan = ov; pix_off = px; menu_idx = ix;
    row_ready = 1;
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    ea = mb & ~20'h1;
    pm = 0;
    for (int r = 0; r < 64; r++) begin
      em = (r > int'(ix));
      if (r == 0) begin
        areq = "R2 base";
      end else if (em && !pm) begin
        ea = nb & ~20'h1; areq = "R6 menu base";
      end else if (em) begin
        ea = ea + 20'(2 * RB); areq = "R7 menu step";
      end else begin
        ea = ea + 20'(2 * (RB + int'(ov) + (px >= 3'd4 ? 1 : 0)));
        areq = (px >= 3'd4) ? "R5 extra byte" : "R4 main step";
      end
      if (stall) areq = {areq, " R9"};
      mreq = (ix == 6'd63) ? "R8 no menu" : "R6 region";
      check_row(r, ea, em, areq, mreq);
      pm = em;
      if (stall && (r % 7 == 3 || r == int'(ix) || r == 63)) begin
        row_ready = 0;
        frame_start = 1;
        main_base = ~mb; menu_base = ~nb; overscan = ~ov; pix_off = ~px;
        menu_idx = ~ix;
        @(negedge clk);
        frame_start = 0;
        chk(row_valid === 1'b1 && row_num === 6'(r) && row_addr === ea &&
            row_is_menu === em, "R3 hold", 32'(row_addr), 32'(ea));
        row_ready = 1;
      end
      @(negedge clk);
    end
    chk(frame_done === 1'b1, "R10 done high", 32'(frame_done), 1);
    chk(row_valid === 1'b0, "R10 idle", 32'(row_valid), 0);
    @(negedge clk);
    chk(frame_done === 1'b0, "R10 single pulse", 32'(frame_done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(row_valid === 1'b0, "R1 reset valid", 32'(row_valid), 0);
    chk(frame_done === 1'b0, "R1 reset done", 32'(frame_done), 0);
    rst = 0;
    @(negedge clk);
    chk(row_valid === 1'b0, "R1 idle after reset", 32'(row_valid), 0);

    for (int v = 0; v < NV; v++)
      run_frame(V_MAIN[v], V_MENU[v], V_OVS[v], V_PIX[v], V_IDX[v], 1'b0);

    run_frame(20'h3A5C1, 20'h7E003, 12'd5, 3'd6, 6'd40, 1'b1);
    run_frame(20'h00010, 20'h00800, 12'd2, 3'd1, 6'd62, 1'b1);

    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(row_valid === 1'b0, "R1 mid-frame reset", 32'(row_valid), 0);
    @(negedge clk);
    chk(row_valid === 1'b0 && frame_done === 1'b0, "R1 stays idle",
        32'(row_valid), 0);

    run_frame(20'h0ABCD, 20'h0DCBA, 12'd0, 3'd2, 6'd1, 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule